// File: doc/BRIEF.md
# Bank translation and permission unit

This block sits between a CPU with a 24-bit address bus and a larger physical memory. The top eight address bits choose a 64 KiB page. That page number, joined with a 2-bit context number, indexes an on-chip table of 1024 entries. Each entry gives a 12-bit frame number, which replaces the page bits to form a 28-bit physical address, and four permission flags. Each of the four contexts has its own address map. Any page, including the low page that holds the stack and direct page, can sit at any physical frame.

Every bus cycle is checked against the entry's flags, the live cycle type and the privilege mode. A cycle that breaks a rule never reaches memory: chip-enable and the write strobe stay low, and a one-cycle fault pulse is raised. The page and context of the most recent faulting access are held for supervisor software to read. The table has its own write port, and that port accepts writes only in supervisor mode. Until an entry is written, it behaves as an identity mapping with no flags set, so the system can boot from an empty table.

Top module: `bank_xlate`

## Requirements
- R1: The physical address is {frame, cpu_addr[15:0]}, where frame is bits [11:0] of the entry at index {ctx_id, cpu_addr[23:16]}. The outputs for a request appear in the cycle after the one in which it is presented.
- R2: Each context number selects a separate group of 256 entries, so one CPU address can map to different frames in different contexts.
- R3: After reset, any entry that has not been written reads as frame = zero-extended page number with all flags clear. This holds for every context.
- R4: Entry bits are: [11:0] frame, bit 12 no-write, bit 13 no-read, bit 14 no-execute, bit 15 supervisor-only.
- R5: A cycle is a bus access when cpu_vpa or cpu_vda is high. An access with cpu_rnw=0 on a no-write page faults. An access with cpu_rnw=1 on a no-read page faults, and this includes opcode fetches.
- R6: An opcode fetch is a cycle with cpu_vpa and cpu_vda both high. A fetch from a no-execute page faults. Reads with only one of the two strobes high are allowed on such a page.
- R7: An access to a supervisor-only page faults when sup_mode is low and is allowed when it is high.
- R8: On an access fault, mem_ce and mem_we are low and fault is high for exactly that one output cycle. A permitted access drives mem_ce high, and also drives mem_we high when it is a write.
- R9: A cycle with cpu_vpa and cpu_vda both low drives mem_ce and mem_we low and raises no fault, whatever the flags.
- R10: fault_page and fault_ctx take the page and context of an access fault one cycle after the fault output, and hold them until the next access fault. Both read zero after reset.
- R11: A table write with tw_en and sup_mode high updates entry tw_idx (bits [9:8] context, [7:0] page) with tw_data. A lookup presented in the next cycle or later sees the new entry.
- R12: A table write with sup_mode low leaves the table unchanged and raises fault in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 24 | CPU address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_vpa | input | 1 | Valid program address strobe |
| cpu_vda | input | 1 | Valid data address strobe |
| sup_mode | input | 1 | Supervisor privilege level |
| ctx_id | input | 2 | Active context number |
| tw_en | input | 1 | Table write request |
| tw_idx | input | 10 | Table write index {context, page} |
| tw_data | input | 16 | Table write data |
| phys_addr | output | 28 | Translated physical address |
| mem_ce | output | 1 | Memory chip-enable |
| mem_we | output | 1 | Memory write strobe |
| fault | output | 1 | One-cycle violation pulse |
| fault_page | output | 8 | Page of the last access fault |
| fault_ctx | output | 2 | Context of the last access fault |

## Verification
The bench targets the boundaries between cycle types. If the strobe decoding were wrong, a read with only cpu_vpa high on a no-execute page would fault, or a real fetch would slip past. It also checks that an idle cycle on a restricted page stays quiet, that no-read covers fetches, and that the supervisor flag gives way when sup_mode is high. On the table side it reads unwritten entries in several contexts, which would come back as garbage if the identity fallback were missing. It then issues a lookup in the cycle after a table write, which a design with an extra write delay would serve stale. Finally it sends a user-mode write and confirms that the write both faults and leaves the entry unchanged.

// File: rtl/bx_pkg.sv
package bx_pkg;
  // Permission flags sit above the frame number in each entry.
  localparam int FLAG_W = 4;
  localparam int FLG_NOWR = 0;
  localparam int FLG_NORD = 1;
  localparam int FLG_NOEX = 2;
  localparam int FLG_SUP  = 3;

  typedef struct packed {
    logic active;
    logic rd;
    logic wr;
    logic fetch;
  } acc_t;
endpackage

// File: rtl/bx_table.sv
module bx_table #(
  parameter int IDX_W = 10,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rd_q,
  output logic             hit_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written;

  // Plain synchronous RAM, no reset, so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rd_q <= mem[ridx];
  end

  // One flag per entry marks entries software has filled.
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      hit_q   <= 1'b0;
    end else begin
      if (we) written[widx] <= 1'b1;
      hit_q <= written[ridx];
    end
  end
endmodule

// File: rtl/bx_perm.sv
module bx_perm
  import bx_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  acc_t              acc,
  input  logic              sup,
  output logic              viol
);
  always_comb begin
    viol = 1'b0;
    if (acc.active) begin
      if (flags[FLG_SUP] && !sup)        viol = 1'b1;
      if (flags[FLG_NOWR] && acc.wr)     viol = 1'b1;
      if (flags[FLG_NORD] && acc.rd)     viol = 1'b1;
      if (flags[FLG_NOEX] && acc.fetch)  viol = 1'b1;
    end
  end
endmodule

// File: rtl/bx_status.sv
module bx_status #(
  parameter int PAGE_BITS = 8,
  parameter int CTX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set,
  input  logic [PAGE_BITS-1:0] page,
  input  logic [CTX_W-1:0]     ctx,
  output logic [PAGE_BITS-1:0] page_q,
  output logic [CTX_W-1:0]     ctx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      ctx_q  <= '0;
    end else if (set) begin
      page_q <= page;
      ctx_q  <= ctx;
    end
  end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bx_pkg::*;
#(
  parameter int VA_W      = 24,
  parameter int PAGE_BITS = 8,
  parameter int CTX_W     = 2,
  parameter int FRAME_W   = 12,
  localparam int IDX_W    = CTX_W + PAGE_BITS,
  localparam int OFF_W    = VA_W - PAGE_BITS,
  localparam int ENT_W    = FLAG_W + FRAME_W,
  localparam int PA_W     = FRAME_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [VA_W-1:0]      cpu_addr,
  input  logic                 cpu_rnw,
  input  logic                 cpu_vpa,
  input  logic                 cpu_vda,
  input  logic                 sup_mode,
  input  logic [CTX_W-1:0]     ctx_id,
  input  logic                 tw_en,
  input  logic [IDX_W-1:0]     tw_idx,
  input  logic [ENT_W-1:0]     tw_data,
  output logic [PA_W-1:0]      phys_addr,
  output logic                 mem_ce,
  output logic                 mem_we,
  output logic                 fault,
  output logic [PAGE_BITS-1:0] fault_page,
  output logic [CTX_W-1:0]     fault_ctx
);
  // Request stage: capture the untranslated parts alongside the RAM read.
  logic [OFF_W-1:0]     off_q;
  logic [PAGE_BITS-1:0] page_q;
  logic [CTX_W-1:0]     ctx_q;
  logic                 sup_q;
  logic                 rej_q;
  acc_t                 acc_d, acc_q;

  logic [PAGE_BITS-1:0] page_d;
  logic                 tw_ok;

  assign page_d = cpu_addr[VA_W-1:OFF_W];
  assign tw_ok  = tw_en && sup_mode;

  always_comb begin
    acc_d.active = cpu_vpa || cpu_vda;
    acc_d.fetch  = cpu_vpa && cpu_vda;
    acc_d.rd     = acc_d.active && cpu_rnw;
    acc_d.wr     = acc_d.active && !cpu_rnw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      page_q <= '0;
      ctx_q  <= '0;
      sup_q  <= 1'b0;
      rej_q  <= 1'b0;
      acc_q  <= '0;
    end else begin
      off_q  <= cpu_addr[OFF_W-1:0];
      page_q <= page_d;
      ctx_q  <= ctx_id;
      sup_q  <= sup_mode;
      rej_q  <= tw_en && !sup_mode;
      acc_q  <= acc_d;
    end
  end

  logic [ENT_W-1:0] ram_q;
  logic             hit_q;

  bx_table #(.IDX_W(IDX_W), .DW(ENT_W)) u_table (
    .clk   (clk),
    .rst   (rst),
    .we    (tw_ok),
    .widx  (tw_idx),
    .wdata (tw_data),
    .ridx  ({ctx_id, page_d}),
    .rd_q  (ram_q),
    .hit_q (hit_q)
  );

  // Identity frame for entries never written.
  logic [FRAME_W-1:0] ident_frame;
  generate
    if (FRAME_W > PAGE_BITS) begin : g_pad
      assign ident_frame = {{(FRAME_W-PAGE_BITS){1'b0}}, page_q};
    end else begin : g_trunc
      assign ident_frame = page_q[FRAME_W-1:0];
    end
  endgenerate

  logic [ENT_W-1:0]  entry;
  logic [FLAG_W-1:0] flags;
  logic [FRAME_W-1:0] frame;
  logic              acc_fault;

  assign entry = hit_q ? ram_q : {{FLAG_W{1'b0}}, ident_frame};
  assign flags = entry[ENT_W-1:FRAME_W];
  assign frame = entry[FRAME_W-1:0];

  bx_perm u_perm (
    .flags (flags),
    .acc   (acc_q),
    .sup   (sup_q),
    .viol  (acc_fault)
  );

  assign phys_addr = {frame, off_q};
  assign mem_ce    = acc_q.active && !acc_fault;
  assign mem_we    = acc_q.wr && !acc_fault;
  assign fault     = acc_fault || rej_q;

  bx_status #(.PAGE_BITS(PAGE_BITS), .CTX_W(CTX_W)) u_status (
    .clk    (clk),
    .rst    (rst),
    .set    (acc_fault),
    .page   (page_q),
    .ctx    (ctx_q),
    .page_q (fault_page),
    .ctx_q  (fault_ctx)
  );
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter int VA_W      = 24,
  parameter int PAGE_BITS = 8,
  parameter int CTX_W     = 2,
  parameter int PA_W      = 28,
  parameter int OFF_W     = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [VA_W-1:0]      cpu_addr,
  input logic                 cpu_vpa,
  input logic                 cpu_vda,
  input logic                 sup_mode,
  input logic                 tw_en,
  input logic [PA_W-1:0]      phys_addr,
  input logic                 mem_ce,
  input logic                 mem_we,
  input logic                 fault,
  input logic [PAGE_BITS-1:0] fault_page,
  input logic [CTX_W-1:0]     fault_ctx,
  input logic                 acc_fault,
  input logic [PAGE_BITS-1:0] page_q,
  input logic [CTX_W-1:0]     ctx_q
);
  // R8: a blocked access never reaches memory
  p_block_on_fault_r8: assert property (@(posedge clk) disable iff (rst)
    acc_fault |-> (!mem_ce && !mem_we));

  // R8: write strobe only accompanies an enabled access
  p_we_with_ce_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_ce);

  // R9: idle cycles stay off the bus
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!cpu_vpa && !cpu_vda) |=> (!mem_ce && !acc_fault));

  // R12: rejected table write is flagged
  p_reject_flag_r12: assert property (@(posedge clk) disable iff (rst)
    (tw_en && !sup_mode) |=> fault);

  // R10: status captures the faulting page and context
  p_status_load_r10: assert property (@(posedge clk) disable iff (rst)
    acc_fault |=> (fault_page == $past(page_q) && fault_ctx == $past(ctx_q)));

  // R10: status holds without a new access fault
  p_status_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_fault |=> ($stable(fault_page) && $stable(fault_ctx)));

  // R1: page offset passes through untouched
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_vpa || cpu_vda) |=> (phys_addr[OFF_W-1:0] == $past(cpu_addr[OFF_W-1:0])));
endmodule

bind bank_xlate bank_xlate_chk #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .CTX_W(CTX_W), .PA_W(PA_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_vpa(cpu_vpa), .cpu_vda(cpu_vda),
  .sup_mode(sup_mode), .tw_en(tw_en), .phys_addr(phys_addr), .mem_ce(mem_ce),
  .mem_we(mem_we), .fault(fault), .fault_page(fault_page), .fault_ctx(fault_ctx),
  .acc_fault(acc_fault), .page_q(page_q), .ctx_q(ctx_q)
);

// File: tb/tb_bank_xlate.sv
`timescale 1ns/1ps
module tb_bank_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] cpu_addr;
  logic        cpu_rnw, cpu_vpa, cpu_vda, sup_mode;
  logic [1:0]  ctx_id;
  logic        tw_en;
  logic [9:0]  tw_idx;
  logic [15:0] tw_data;
  logic [27:0] phys_addr;
  logic        mem_ce, mem_we, fault;
  logic [7:0]  fault_page;
  logic [1:0]  fault_ctx;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  bank_xlate dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
    .cpu_vpa(cpu_vpa), .cpu_vda(cpu_vda), .sup_mode(sup_mode), .ctx_id(ctx_id),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data), .phys_addr(phys_addr),
    .mem_ce(mem_ce), .mem_we(mem_we), .fault(fault),
    .fault_page(fault_page), .fault_ctx(fault_ctx)
  );

  // Vector: {ctx[2], addr[24], rnw, vpa, vda, mode, exp_phys[28], exp_ce, exp_we, exp_fault}
  localparam int NV = 13;
  localparam logic [60:0] VEC [NV] = '{
    {2'd0, 24'h001234, 4'b1010, 28'h1231234, 3'b100},  // R1 R4 plain map
    {2'd1, 24'h001234, 4'b1010, 28'h4561234, 3'b100},  // R2 other context
    {2'd0, 24'h010010, 4'b0010, 28'hABC0010, 3'b001},  // R5 write to no-write
    {2'd0, 24'h010010, 4'b1010, 28'hABC0010, 3'b100},  // R5 R8 read ok, pulse gone
    {2'd0, 24'h020020, 4'b1010, 28'h0050020, 3'b001},  // R5 read of no-read
    {2'd0, 24'h020020, 4'b0010, 28'h0050020, 3'b110},  // R5 R8 write allowed
    {2'd0, 24'h030030, 4'b1110, 28'h7FF0030, 3'b001},  // R6 fetch of no-exec
    {2'd0, 24'h030030, 4'b1010, 28'h7FF0030, 3'b100},  // R6 data read
    {2'd0, 24'h030030, 4'b1100, 28'h7FF0030, 3'b100},  // R6 program-only read
    {2'd0, 24'h040040, 4'b1010, 28'hFFF0040, 3'b001},  // R7 user on sup page
    {2'd0, 24'h040040, 4'b0011, 28'hFFF0040, 3'b110},  // R7 supervisor write
    {2'd2, 24'h801234, 4'b1010, 28'h0801234, 3'b100},  // R3 unwritten entry
    {2'd0, 24'h020020, 4'b1000, 28'h0050020, 3'b000}   // R9 idle on no-read page
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R1 R4";
      1: return "R2";
      2, 4: return "R5";
      3, 5: return "R5 R8";
      6, 7, 8: return "R6";
      9, 10: return "R7";
      11: return "R3";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_vpa = 1'b0; cpu_vda = 1'b0; tw_en = 1'b0;
  endtask

  // Present one access at a falling edge; outputs are sampled one cycle later.
  task automatic access(input logic [1:0] c, input logic [23:0] a, input logic rnw,
                        input logic vpa, input logic vda, input logic m);
    ctx_id = c; cpu_addr = a; cpu_rnw = rnw; cpu_vpa = vpa; cpu_vda = vda; sup_mode = m;
    @(negedge clk);
    idle();
  endtask

  task automatic twrite(input logic [9:0] idx, input logic [15:0] d, input logic m);
    tw_en = 1'b1; tw_idx = idx; tw_data = d; sup_mode = m;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_addr = '0; cpu_rnw = 1'b1; sup_mode = 1'b0; ctx_id = '0;
    tw_idx = '0; tw_data = '0; idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state (R8 R10)
    check(!mem_ce && !mem_we && !fault, "R8 reset outputs",
          {61'd0, mem_ce, mem_we, fault}, 64'd0);
    check(fault_page == 8'd0 && fault_ctx == 2'd0, "R10 reset status",
          {54'd0, fault_ctx, fault_page}, 64'd0);

    // Supervisor fills the table (R4 layout, R11 index format)
    twrite(10'h000, 16'h0123, 1'b1);
    twrite(10'h001, 16'h1ABC, 1'b1);  // no-write
    twrite(10'h002, 16'h2005, 1'b1);  // no-read
    twrite(10'h003, 16'h47FF, 1'b1);  // no-execute
    twrite(10'h004, 16'h8FFF, 1'b1);  // supervisor-only
    twrite(10'h100, 16'h0456, 1'b1);  // context 1, page 0
    check(!fault, "R11 accepted writes raise no fault", {63'd0, fault}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [60:0] v;
      v = VEC[i];
      access(v[60:59], v[58:35], v[34], v[33], v[32], v[31]);
      check({phys_addr, mem_ce, mem_we, fault} == v[30:0], vec_req(i),
            {33'd0, phys_addr, mem_ce, mem_we, fault}, {33'd0, v[30:0]});
    end

    // R10: last access fault in the table was page 0x04 context 0, held since
    check(fault_page == 8'h04 && fault_ctx == 2'd0, "R10 status held",
          {54'd0, fault_ctx, fault_page}, {54'd0, 2'd0, 8'h04});

    // R12: user-mode table write is rejected and flagged
    twrite(10'h000, 16'h0999, 1'b0);
    check(fault && !mem_ce, "R12 rejected write pulses fault",
          {62'd0, fault, mem_ce}, 64'd2);
    access(2'd0, 24'h00ABCD, 1'b1, 1'b0, 1'b1, 1'b0);
    check(phys_addr == 28'h123ABCD && mem_ce, "R12 entry unchanged",
          {36'd0, phys_addr}, {36'd0, 28'h123ABCD});
    check(fault_page == 8'h04, "R12 status untouched by rejected write",
          {56'd0, fault_page}, {56'd0, 8'h04});

    // R11: lookup in the cycle right after a write sees the new entry
    twrite(10'h310, 16'h8321, 1'b1);
    access(2'd3, 24'h105555, 1'b0, 1'b0, 1'b1, 1'b1);
    check(phys_addr == 28'h3215555 && mem_ce && mem_we && !fault, "R11 write visible next cycle",
          {33'd0, phys_addr, mem_ce, mem_we, fault}, {33'd0, 28'h3215555, 3'b110});

    // R10 R7: user access to new supervisor page latches its page and context
    access(2'd3, 24'h100001, 1'b1, 1'b0, 1'b1, 1'b0);
    check(fault && !mem_ce, "R7 user fault on context 3",
          {62'd0, fault, mem_ce}, 64'd2);
    @(negedge clk);
    check(!fault, "R8 fault lasts one cycle", {63'd0, fault}, 64'd0);
    check(fault_page == 8'h10 && fault_ctx == 2'd3, "R10 status captures context 3",
          {54'd0, fault_ctx, fault_page}, {54'd0, 2'd3, 8'h10});

    // R5: no-read covers opcode fetches
    access(2'd0, 24'h020000, 1'b1, 1'b1, 1'b1, 1'b1);
    check(fault && !mem_ce, "R5 fetch from no-read page", {62'd0, fault, mem_ce}, 64'd2);

    // R3: reset brings back the identity map
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(2'd0, 24'h010010, 1'b0, 1'b0, 1'b1, 1'b0);
    check(phys_addr == 28'h0010010 && mem_ce && mem_we && !fault, "R3 identity after reset",
          {33'd0, phys_addr, mem_ce, mem_we, fault}, {33'd0, 28'h0010010, 3'b110});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule